// File: doc/BRIEF.md
# Machine-Mode Trap Controller with Non-Maskable Interrupt

This block decides, every cycle, whether a hart must leave its current instruction stream for an interrupt handler, which handler and at which privilege level. It arbitrates among the standard maskable interrupt lines, applies the global enables and the delegation mask, and computes the new values of the cause, exception PC, trap value and status fields. The core applies them on the same clock edge that the take-trap strobe marks. On a return from a machine-mode handler it computes the restored privilege and status fields.

Beside the maskable sources the block holds a minimal non-maskable interrupt (NMI). It keeps three private flags: a pending flag, a self-mask flag and a sticky "trap state may be lost" flag. It also keeps a vector register, which has a reset value and no write path. No software-visible control touches them. An NMI always wins over the maskable lines, is never delegated, and masks itself until the next machine return.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every input is a level or a single-cycle strobe sampled at the rising clock edge. Every trap output is combinational from the current inputs and the internal flags, and is meant to be consumed in the same cycle.

Top module: `nmi_trap_ctrl`

## Requirements
- R1: After reset the NMI is neither pending nor masked, the lost-state flag is 0 and the NMI vector holds NMI_VEC_RST (default 0). With no pending source, take_trap_o and priv_we_o are 0.
- R2: A cycle with nmi_post_i high sets the NMI pending flag at that edge, even when nmi_clr_i or clr_all_i is also high. An NMI is taken in any cycle where both the pending flag and the enable (self-mask) flag are 1.
- R3: nmi_clr_i, or clr_all_i, without nmi_post_i clears the pending flag at that edge, so no NMI is taken afterwards.
- R4: A taken NMI beats every maskable source. It goes to machine mode (priv_o = 2'b11) whatever the current privilege or delegation. It writes cause 0 and trap value 0.
- R5: The NMI handler address is the NMI vector with bits [1:0] forced to 0.
- R6: NMI entry clears the enable flag, so an NMI that is still pending is not taken again until the next mret.
- R7: In an mret cycle no trap is taken. The enable flag is set at that edge. priv_o = mpp_i, mie_o = mpie_i, mpie_o = 1, mpp_o = 2'b00 (user), and status_we_o and priv_we_o are 1.
- R8: A maskable interrupt goes to supervisor mode (priv_o = 2'b01) only when priv_i is not 2'b11 and its bit in irq_deleg_i is 1; otherwise it goes to machine mode. The handler is stvec_i or mtvec_i respectively, with bits [1:0] zeroed. The cause is the MSB set plus the line number in the low bits.
- R9: Only lines 11, 7, 3, 9, 5 and 1 are interrupt sources, taken in that priority order (11 highest). All other bits are ignored. A line is a candidate only when both its pending bit and its enable bit are 1.
- R10: A candidate bound for machine mode is enabled when priv_i is not machine or mie_i is 1. A candidate bound for supervisor mode is enabled when priv_i is user, or when priv_i is supervisor and sie_i is 1. Priority picks among enabled candidates only.
- R11: Trap entry writes epc_o = pc_i and tval_o = 0. Machine entry gives mpp_o = priv_i, mpie_o = mie_i and mie_o = 0. Supervisor entry gives spp_o = priv_i[0], spie_o = sie_i and sie_o = 0. The other status fields pass through unchanged.
- R12: An NMI taken while priv_i is machine and mie_i is 0 is still taken. It sets nmi_lost_o at that edge, and the flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_post_i | input | 1 | Strobe: raise the NMI |
| nmi_clr_i | input | 1 | Strobe: withdraw the NMI |
| clr_all_i | input | 1 | Strobe: clear-all request; drops the pending NMI |
| irq_pend_i | input | NIRQ | Maskable pending bits |
| irq_en_i | input | NIRQ | Maskable enable bits |
| irq_deleg_i | input | NIRQ | Delegation bits (1 = to supervisor) |
| priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| mie_i | input | 1 | Machine global enable |
| mpie_i | input | 1 | Machine previous enable |
| mpp_i | input | 2 | Machine previous privilege |
| sie_i | input | 1 | Supervisor global enable |
| spie_i | input | 1 | Supervisor previous enable |
| spp_i | input | 1 | Supervisor previous privilege |
| mtvec_i | input | XLEN | Machine trap vector |
| stvec_i | input | XLEN | Supervisor trap vector |
| pc_i | input | XLEN | PC of the current instruction |
| mret_i | input | 1 | Strobe: machine return executes |
| take_trap_o | output | 1 | A trap is taken this cycle |
| priv_we_o | output | 1 | Privilege update strobe |
| priv_o | output | 2 | New privilege |
| status_we_o | output | 1 | Status update strobe |
| mie_o | output | 1 | New machine global enable |
| mpie_o | output | 1 | New machine previous enable |
| mpp_o | output | 2 | New machine previous privilege |
| sie_o | output | 1 | New supervisor global enable |
| spie_o | output | 1 | New supervisor previous enable |
| spp_o | output | 1 | New supervisor previous privilege |
| cause_we_o | output | 1 | Cause update strobe (register chosen by priv_o) |
| cause_o | output | XLEN | Cause value |
| epc_we_o | output | 1 | Exception PC update strobe |
| epc_o | output | XLEN | Exception PC value |
| tval_we_o | output | 1 | Trap value update strobe |
| tval_o | output | XLEN | Trap value |
| handler_o | output | XLEN | Handler address |
| nmi_lost_o | output | 1 | Sticky: an NMI may have overwritten machine trap state |

## Verification
The assertions assume the core applies every update the block emits in the same cycle. They also assume mret_i is a strobe that the core never holds across a trap, so the self-mask flag is never cleared and set on the same edge. The bench keeps to this: it raises mret only on its own cycle and drops every strobe at the next falling edge. After a maskable trap it clears the relevant pending bits or enables before the next check, as a handler would. Each flag change is made with one strobe and then observed through take_trap_o or nmi_lost_o in the following cycle.

// File: rtl/nmi_trap_pkg.sv
package nmi_trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  // Maskable sources in falling priority; entry 0 wins.
  localparam int unsigned NUM_ORD = 6;
  localparam int unsigned IRQ_ORDER [NUM_ORD] = '{11, 7, 3, 9, 5, 1};

endpackage

// File: rtl/nmi_state.sv
module nmi_state
  import nmi_trap_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter logic [XLEN-1:0] NMI_VEC_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            post_i,
  input  logic            clr_i,
  input  logic            clr_all_i,
  input  logic            take_nmi_i,
  input  logic            mret_i,
  input  logic            lost_evt_i,
  output logic            active_o,
  output logic [XLEN-1:0] vec_o,
  output logic            lost_o
);

  logic            pend_q;
  logic            armed_q;
  logic            lost_q;
  logic [XLEN-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b1;
      lost_q  <= 1'b0;
      vec_q   <= NMI_VEC_RST;
    end else begin
      if (post_i)                  pend_q <= 1'b1;
      else if (clr_i || clr_all_i) pend_q <= 1'b0;

      if (take_nmi_i)  armed_q <= 1'b0;
      else if (mret_i) armed_q <= 1'b1;

      if (lost_evt_i) lost_q <= 1'b1;
    end
  end

  assign active_o = pend_q && armed_q;
  assign vec_o    = vec_q;
  assign lost_o   = lost_q;

  AST_POST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    post_i |=> pend_q); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || clr_all_i) && !post_i |=> !pend_q); // R3
  AST_SELF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_i |=> !armed_q); // R6
  AST_MRET_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    mret_i |=> armed_q); // R7
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |=> lost_q); // R12

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import nmi_trap_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  localparam int unsigned CW  = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic            valid_o,
  output logic [CW-1:0]   code_o,
  output logic            to_s_o
);

  logic [NIRQ-1:0] cand;
  logic [NIRQ-1:0] to_s;

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    logic dlg, open;
    assign dlg  = (priv_i != PRIV_M) && deleg_i[g];
    assign open = dlg ? ((priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_i))
                      : ((priv_i != PRIV_M) || mie_i);
    assign cand[g] = pend_i[g] && en_i[g] && open;
    assign to_s[g] = dlg;
  end

  always_comb begin
    valid_o = 1'b0;
    code_o  = '0;
    to_s_o  = 1'b0;
    for (int k = NUM_ORD - 1; k >= 0; k--) begin
      if (cand[IRQ_ORDER[k]]) begin
        valid_o = 1'b1;
        code_o  = CW'(IRQ_ORDER[k]);
        to_s_o  = to_s[IRQ_ORDER[k]];
      end
    end
  end

  AST_NO_SOURCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & en_i) == '0) |-> !valid_o); // R9
  AST_M_NEVER_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && (priv_i == PRIV_M) |-> !to_s_o); // R8

endmodule

// File: rtl/trap_update.sv
module trap_update
  import nmi_trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_act_i,
  input  logic            irq_valid_i,
  input  logic [CW-1:0]   irq_code_i,
  input  logic            irq_to_s_i,
  input  logic            mret_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            mpie_i,
  input  logic [1:0]      mpp_i,
  input  logic            sie_i,
  input  logic            spie_i,
  input  logic            spp_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] nmi_vec_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            take_o,
  output logic            take_nmi_o,
  output logic            lost_evt_o,
  output logic            priv_we_o,
  output logic [1:0]      priv_o,
  output logic            status_we_o,
  output logic            mie_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic            sie_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic            cause_we_o,
  output logic [XLEN-1:0] cause_o,
  output logic            epc_we_o,
  output logic [XLEN-1:0] epc_o,
  output logic            tval_we_o,
  output logic [XLEN-1:0] tval_o,
  output logic [XLEN-1:0] handler_o
);

  logic            tgt_s;
  logic [XLEN-1:0] vec_sel;

  assign take_o     = !mret_i && (nmi_act_i || irq_valid_i);
  assign take_nmi_o = take_o && nmi_act_i;
  assign tgt_s      = !nmi_act_i && irq_to_s_i;
  assign lost_evt_o = take_nmi_o && (priv_i == PRIV_M) && !mie_i;

  assign priv_we_o   = take_o || mret_i;
  assign status_we_o = take_o || mret_i;
  assign priv_o      = mret_i ? mpp_i : (tgt_s ? PRIV_S : PRIV_M);

  always_comb begin
    mie_o  = mie_i;
    mpie_o = mpie_i;
    mpp_o  = mpp_i;
    sie_o  = sie_i;
    spie_o = spie_i;
    spp_o  = spp_i;
    if (mret_i) begin
      mie_o  = mpie_i;
      mpie_o = 1'b1;
      mpp_o  = PRIV_U;
    end else if (take_o && tgt_s) begin
      spp_o  = priv_i[0];
      spie_o = sie_i;
      sie_o  = 1'b0;
    end else if (take_o) begin
      mpp_o  = priv_i;
      mpie_o = mie_i;
      mie_o  = 1'b0;
    end
  end

  always_comb begin
    cause_o = '0;
    if (!nmi_act_i) begin
      cause_o[XLEN-1] = 1'b1;
      cause_o[CW-1:0] = irq_code_i;
    end
  end

  assign vec_sel    = nmi_act_i ? nmi_vec_i : (tgt_s ? stvec_i : mtvec_i);
  assign handler_o  = {vec_sel[XLEN-1:2], 2'b00};
  assign cause_we_o = take_o;
  assign epc_we_o   = take_o;
  assign epc_o      = pc_i;
  assign tval_we_o  = take_o;
  assign tval_o     = '0;

  AST_NMI_TO_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> (priv_o == PRIV_M) && (cause_o == '0)); // R4
  AST_HANDLER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (handler_o[1:0] == 2'b00)); // R5
  AST_NMI_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |=> !take_nmi_o); // R6
  AST_MRET_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mret_i |-> !take_o && mpie_o && (mpp_o == PRIV_U)); // R7
  AST_MENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && (priv_o == PRIV_M) |-> !mie_o && (epc_o == pc_i)); // R11

endmodule

// File: rtl/nmi_trap_ctrl.sv
module nmi_trap_ctrl
  import nmi_trap_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     NIRQ        = 16,
  parameter logic [XLEN-1:0] NMI_VEC_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_post_i,
  input  logic            nmi_clr_i,
  input  logic            clr_all_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NIRQ-1:0] irq_deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            mpie_i,
  input  logic [1:0]      mpp_i,
  input  logic            sie_i,
  input  logic            spie_i,
  input  logic            spp_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            mret_i,
  output logic            take_trap_o,
  output logic            priv_we_o,
  output logic [1:0]      priv_o,
  output logic            status_we_o,
  output logic            mie_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic            sie_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic            cause_we_o,
  output logic [XLEN-1:0] cause_o,
  output logic            epc_we_o,
  output logic [XLEN-1:0] epc_o,
  output logic            tval_we_o,
  output logic [XLEN-1:0] tval_o,
  output logic [XLEN-1:0] handler_o,
  output logic            nmi_lost_o
);

  localparam int unsigned CW = $clog2(NIRQ);

  logic            nmi_act, take_nmi, lost_evt;
  logic            irq_valid, irq_to_s;
  logic [CW-1:0]   irq_code;
  logic [XLEN-1:0] nmi_vec;

  nmi_state #(.XLEN(XLEN), .NMI_VEC_RST(NMI_VEC_RST)) u_state (
    .clk(clk), .rst_n(rst_n),
    .post_i(nmi_post_i), .clr_i(nmi_clr_i), .clr_all_i(clr_all_i),
    .take_nmi_i(take_nmi), .mret_i(mret_i), .lost_evt_i(lost_evt),
    .active_o(nmi_act), .vec_o(nmi_vec), .lost_o(nmi_lost_o)
  );

  irq_arbiter #(.NIRQ(NIRQ)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pend_i(irq_pend_i), .en_i(irq_en_i), .deleg_i(irq_deleg_i),
    .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i),
    .valid_o(irq_valid), .code_o(irq_code), .to_s_o(irq_to_s)
  );

  trap_update #(.XLEN(XLEN), .CW(CW)) u_upd (
    .clk(clk), .rst_n(rst_n),
    .nmi_act_i(nmi_act), .irq_valid_i(irq_valid), .irq_code_i(irq_code),
    .irq_to_s_i(irq_to_s), .mret_i(mret_i), .priv_i(priv_i),
    .mie_i(mie_i), .mpie_i(mpie_i), .mpp_i(mpp_i),
    .sie_i(sie_i), .spie_i(spie_i), .spp_i(spp_i),
    .mtvec_i(mtvec_i), .stvec_i(stvec_i), .nmi_vec_i(nmi_vec), .pc_i(pc_i),
    .take_o(take_trap_o), .take_nmi_o(take_nmi), .lost_evt_o(lost_evt),
    .priv_we_o(priv_we_o), .priv_o(priv_o), .status_we_o(status_we_o),
    .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
    .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o),
    .cause_we_o(cause_we_o), .cause_o(cause_o),
    .epc_we_o(epc_we_o), .epc_o(epc_o),
    .tval_we_o(tval_we_o), .tval_o(tval_o), .handler_o(handler_o)
  );

  AST_LOST_ONLY_BY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_lost_o && !take_nmi |=> !nmi_lost_o); // R12

endmodule

// File: tb/sim_nmi_trap_ctrl.sv
module sim_nmi_trap_ctrl;

  localparam int unsigned XLEN = 32;
  localparam int unsigned NIRQ = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic rst_n;
  logic nmi_post_i, nmi_clr_i, clr_all_i, mret_i;
  logic [NIRQ-1:0] irq_pend_i, irq_en_i, irq_deleg_i;
  logic [1:0] priv_i, mpp_i;
  logic mie_i, mpie_i, sie_i, spie_i, spp_i;
  logic [XLEN-1:0] mtvec_i, stvec_i, pc_i;
  logic take_trap_o, priv_we_o, status_we_o, cause_we_o, epc_we_o, tval_we_o;
  logic [1:0] priv_o, mpp_o;
  logic mie_o, mpie_o, sie_o, spie_o, spp_o, nmi_lost_o;
  logic [XLEN-1:0] cause_o, epc_o, tval_o, handler_o;

  nmi_trap_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ)) u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  priv;
    logic [11:0] pend;
    logic [11:0] en;
    logic [11:0] deleg;
    logic        mie;
    logic        sie;
    logic        take;
    logic [1:0]  tpriv;
    logic [3:0]  code;
  } vec_t;

  localparam int NV = 11;
  // Maskable arbitration, delegation and enables (R8, R9, R10, R11)
  localparam vec_t VT [NV] = '{
    '{2'b11, 12'h888, 12'hFFF, 12'h000, 1'b1, 1'b0, 1'b1, 2'b11, 4'd11},
    '{2'b11, 12'h088, 12'hFFF, 12'h000, 1'b1, 1'b0, 1'b1, 2'b11, 4'd7},
    '{2'b11, 12'h00A, 12'hFFF, 12'h000, 1'b1, 1'b0, 1'b1, 2'b11, 4'd3},
    '{2'b11, 12'h888, 12'hFFF, 12'h000, 1'b0, 1'b1, 1'b0, 2'b00, 4'd0},
    '{2'b00, 12'h200, 12'hFFF, 12'h200, 1'b0, 1'b0, 1'b1, 2'b01, 4'd9},
    '{2'b11, 12'h200, 12'hFFF, 12'h200, 1'b1, 1'b0, 1'b1, 2'b11, 4'd9},
    '{2'b01, 12'h020, 12'hFFF, 12'h020, 1'b0, 1'b0, 1'b0, 2'b00, 4'd0},
    '{2'b01, 12'h0A0, 12'hFFF, 12'h020, 1'b0, 1'b0, 1'b1, 2'b11, 4'd7},
    '{2'b11, 12'h881, 12'h001, 12'h000, 1'b1, 1'b1, 1'b0, 2'b00, 4'd0},
    '{2'b01, 12'h822, 12'hFFF, 12'h022, 1'b0, 1'b1, 1'b1, 2'b11, 4'd11},
    '{2'b01, 12'h022, 12'hFFF, 12'h022, 1'b0, 1'b1, 1'b1, 2'b01, 4'd5}
  };

  task automatic step();
    @(negedge clk);
    nmi_post_i = 1'b0; nmi_clr_i = 1'b0; clr_all_i = 1'b0; mret_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    nmi_post_i = 1'b0; nmi_clr_i = 1'b0; clr_all_i = 1'b0; mret_i = 1'b0;
    irq_pend_i = '0; irq_en_i = '0; irq_deleg_i = '0;
    priv_i = 2'b11; mpp_i = 2'b00;
    mie_i = 1'b0; mpie_i = 1'b0; sie_i = 1'b0; spie_i = 1'b0; spp_i = 1'b0;
    mtvec_i = 32'h1000_0103; stvec_i = 32'h2000_0206; pc_i = 32'h8000_0040;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 take after reset", take_trap_o, 0);
    chk("R1 priv_we after reset", priv_we_o, 0);
    chk("R1 lost flag after reset", nmi_lost_o, 0);

    for (int i = 0; i < NV; i++) begin
      step();
      priv_i = VT[i].priv; irq_pend_i = {4'b0, VT[i].pend};
      irq_en_i = {4'b0, VT[i].en}; irq_deleg_i = {4'b0, VT[i].deleg};
      mie_i = VT[i].mie; sie_i = VT[i].sie; spp_i = 1'b1; spie_i = 1'b0; mpie_i = 1'b0;
      #2;
      chk($sformatf("R9 R10 vec %0d take", i), take_trap_o, VT[i].take);
      if (VT[i].take) begin
        chk($sformatf("R8 vec %0d priv", i), priv_o, VT[i].tpriv);
        chk($sformatf("R8 vec %0d cause", i), cause_o, 32'h8000_0000 | VT[i].code);
        chk($sformatf("R8 vec %0d handler", i), handler_o,
            (VT[i].tpriv == 2'b01) ? 32'h2000_0204 : 32'h1000_0100);
        chk($sformatf("R11 vec %0d epc", i), epc_o, pc_i);
        chk($sformatf("R11 vec %0d tval", i), tval_o, 0);
        if (VT[i].tpriv == 2'b11) begin
          chk($sformatf("R11 vec %0d mpp", i), mpp_o, VT[i].priv);
          chk($sformatf("R11 vec %0d mpie", i), mpie_o, VT[i].mie);
          chk($sformatf("R11 vec %0d mie", i), mie_o, 0);
          chk($sformatf("R11 vec %0d sie passthru", i), sie_o, VT[i].sie);
        end else begin
          chk($sformatf("R11 vec %0d spp", i), spp_o, VT[i].priv[0]);
          chk($sformatf("R11 vec %0d spie", i), spie_o, VT[i].sie);
          chk($sformatf("R11 vec %0d sie", i), sie_o, 0);
          chk($sformatf("R11 vec %0d mie passthru", i), mie_o, VT[i].mie);
        end
      end
    end

    // Post NMI while a delegated maskable line is pending in user mode
    step();
    priv_i = 2'b00; irq_pend_i = 16'h0800; irq_en_i = '1; irq_deleg_i = '1;
    mie_i = 1'b0; sie_i = 1'b0; mpie_i = 1'b0;
    nmi_post_i = 1'b1;
    #2;
    chk("R2 maskable before NMI visible", priv_o, 2'b01);
    step();
    #2;
    chk("R2 NMI taken", take_trap_o, 1);
    chk("R4 NMI to machine", priv_o, 2'b11);
    chk("R4 NMI cause", cause_o, 0);
    chk("R4 NMI tval", tval_o, 0);
    chk("R5 NMI handler", handler_o, 0);
    chk("R11 NMI mpp", mpp_o, 2'b00);
    step();
    irq_pend_i = '0;
    #2;
    chk("R6 masked while pending", take_trap_o, 0);
    step();
    mret_i = 1'b1; mpp_i = 2'b01; mpie_i = 1'b1;
    #2;
    chk("R7 no trap on mret", take_trap_o, 0);
    chk("R7 priv from mpp", priv_o, 2'b01);
    chk("R7 mie from mpie", mie_o, 1);
    chk("R7 mpie set", mpie_o, 1);
    chk("R7 mpp to user", mpp_o, 2'b00);
    chk("R7 status_we", status_we_o, 1);
    step();
    nmi_clr_i = 1'b1;
    #2;
    chk("R7 NMI re-taken after mret", take_trap_o, 1);
    step();
    mret_i = 1'b1;
    step();
    #2;
    chk("R3 cleared NMI not taken", take_trap_o, 0);

    // Post and clear together; then NMI over machine handler with MIE=0
    step();
    nmi_post_i = 1'b1; nmi_clr_i = 1'b1;
    step();
    priv_i = 2'b11; mie_i = 1'b0;
    #2;
    chk("R2 post beats clear", take_trap_o, 1);
    chk("R12 lost flag before edge", nmi_lost_o, 0);
    step();
    #2;
    chk("R12 lost flag set", nmi_lost_o, 1);
    step();
    mret_i = 1'b1; clr_all_i = 1'b1;
    step();
    #2;
    chk("R3 clear-all drops NMI", take_trap_o, 0);
    chk("R12 lost flag sticky", nmi_lost_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule